// File: doc/BRIEF.md
# Byte ECC Datapath with Test Modes

This block sits between a byte-wide nonvolatile array and its data pins. It adds single-error correction to every stored byte using a 12-bit codeword: 8 data bits and 4 check bits. On the write side, a combinational generator turns the incoming byte into the 4 check bits that are stored beside it. On the read side, the block takes the 12-bit word from the array, computes a 4-bit syndrome and repairs any single flipped bit. It returns the corrected byte one clock later and flags the correction, or flags an uncorrectable pattern.

Three test selects reroute the output so that each piece can be checked on its own:
- Generator loopback latches a byte from the data-in path and shows its generated check bits through a purely combinational path.
- Check-bit readout returns the stored check bits as they are in the array.
- Raw readout returns the stored data bits with no correction. Raw readout can also be held on by a persistent option input, which is separate from the test select.

Top module: `byte_ecc_path`

## Requirements
- R1: Codeword position p (1..12) is bit p-1 of the array word. Check bit k sits at position 2^k (positions 1, 2, 4, 8). The data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11, 12 in ascending order. `wr_check_o[k]` is the even parity of the data bits whose position has bit k set.
- R2: In normal mode, a read of an error-free codeword returns its data byte on `dout_o`, and both flags stay low.
- R3: In normal mode, a read whose syndrome (the XOR of the positions of all set bits) is 1..12 flips that position. The read returns the repaired byte and raises `corrected_o` for exactly one clock. This includes the case where the flipped bit is a check bit.
- R4: In normal mode, a syndrome of 13..15 raises `uncorrectable_o` for one clock, leaves `corrected_o` low and returns the data bits unmodified.
- R5: A read registers its result, so `dout_o` and the flags change on the clock edge where `rd_valid_i` is sampled high. With no read, `dout_o` holds and both flags are low, whatever `rd_word_i` does.
- R6: In raw mode (`raw_mode_i` or `raw_persist_i` high), a read returns the 8 stored data bits uncorrected, and both flags stay low.
- R7: In check-bit mode (`chk_mode_i`), a read returns `{4'b0000, c3, c2, c1, c0}` straight from the array word, and both flags stay low.
- R8: In loopback mode (`loop_mode_i`), `wr_data_i` is captured on each clock edge where `oe_n_i` is low. Through a combinational path, `dout_o` shows `{4'b0000, check bits of the captured byte}`. While `oe_n_i` is high, the captured byte holds and changes on `wr_data_i` have no effect.
- R9: Mode priority is loopback, then check-bit, then raw, then normal. A read issued in loopback mode leaves the registered read result unchanged.
- R10: While reset is asserted, `dout_o`, `corrected_o`, `uncorrectable_o` and the captured loopback byte are all zero. Reset asserts asynchronously and releases two clocks after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_data_i | input | 8 | Data-in byte (write path and loopback source) |
| wr_check_o | output | 4 | Generated check bits for `wr_data_i` |
| rd_word_i | input | 12 | Codeword from the array, position p at bit p-1 |
| rd_valid_i | input | 1 | Read strobe, one read per high cycle |
| oe_n_i | input | 1 | Output enable, active low; captures the loopback byte |
| loop_mode_i | input | 1 | Generator loopback test select |
| chk_mode_i | input | 1 | Stored check-bit readout select |
| raw_mode_i | input | 1 | Uncorrected data readout select |
| raw_persist_i | input | 1 | Persistent option that forces uncorrected readout |
| dout_o | output | 8 | Read result or loopback check bits |
| corrected_o | output | 1 | One-clock pulse: a single-bit repair was applied |
| uncorrectable_o | output | 1 | One-clock pulse: syndrome 13..15 |

## Verification
The assertions assume that the mode selects and `oe_n_i` change only between clock edges. For the loopback check, they also assume that `wr_data_i` is the byte to be compared on the edge where it is captured. The stimulus drives every input on the falling edge and keeps each setting stable across the following rising edge. The bench only enters loopback after the internal reset has released. Every byte value is swept with each of its 12 single-bit flips. Double flips are applied only where the bench's own syndrome arithmetic puts them in the uncorrectable range, so none of the expected results depends on how the design treats miscorrected patterns.

// File: rtl/byte_ecc_pkg.sv
package byte_ecc_pkg;

  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CW_W   = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_RAW    = 2'd1,
    MODE_CHECK  = 2'd2,
    MODE_LOOP   = 2'd3
  } path_mode_e;

  // True when position p (1-based) holds a check bit.
  function automatic logic is_check_pos(input int p);
    return ((p & (p - 1)) == 0);
  endfunction

  // Place data bits into the non-check positions, check positions left zero.
  function automatic logic [CW_W-1:0] scatter_data(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_check_pos(p)) begin
        w[p-1] = d[j];
        j++;
      end
    end
    return w;
  endfunction

  // Pull data bits back out of a codeword.
  function automatic logic [DATA_W-1:0] gather_data(input logic [CW_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_check_pos(p)) begin
        d[j] = w[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // Pull check bits out of a codeword.
  function automatic logic [CHK_W-1:0] gather_check(input logic [CW_W-1:0] w);
    logic [CHK_W-1:0] c;
    for (int k = 0; k < CHK_W; k++) c[k] = w[(1 << k) - 1];
    return c;
  endfunction

  // XOR of the positions of all set bits.
  function automatic logic [CHK_W-1:0] pos_syndrome(input logic [CW_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (w[p-1]) s = s ^ CHK_W'(p);
    end
    return s;
  endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
  import byte_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);
  // With check positions zeroed, the syndrome of the data alone is the check word.
  always_comb check_o = pos_syndrome(scatter_data(data_i));
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import byte_ecc_pkg::*;
(
  input  logic [CW_W-1:0]   word_i,
  output logic [DATA_W-1:0] fixed_o,
  output logic [DATA_W-1:0] raw_o,
  output logic [CHK_W-1:0]  stored_chk_o,
  output logic              single_o,
  output logic              multi_o
);
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  flip_mask;

  always_comb begin
    syn = pos_syndrome(word_i);
    flip_mask = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (syn == CHK_W'(p)) flip_mask[p-1] = 1'b1;
    end
  end

  assign single_o     = (syn != '0) && (syn <= CHK_W'(CW_W));
  assign multi_o      = (syn > CHK_W'(CW_W));
  assign fixed_o      = gather_data(word_i ^ flip_mask);
  assign raw_o        = gather_data(word_i);
  assign stored_chk_o = gather_check(word_i);
endmodule

// File: rtl/ecc_mode_pick.sv
module ecc_mode_pick
  import byte_ecc_pkg::*;
(
  input  logic       loop_i,
  input  logic       chk_i,
  input  logic       raw_i,
  input  logic       persist_i,
  output path_mode_e mode_o
);
  always_comb begin
    if (loop_i)                  mode_o = MODE_LOOP;
    else if (chk_i)              mode_o = MODE_CHECK;
    else if (raw_i || persist_i) mode_o = MODE_RAW;
    else                         mode_o = MODE_NORMAL;
  end
endmodule

// File: rtl/byte_ecc_path.sv
module byte_ecc_path
  import byte_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CHK_W-1:0]  wr_check_o,
  input  logic [CW_W-1:0]   rd_word_i,
  input  logic              rd_valid_i,
  input  logic              oe_n_i,
  input  logic              loop_mode_i,
  input  logic              chk_mode_i,
  input  logic              raw_mode_i,
  input  logic              raw_persist_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  localparam int SYNC_W = 2;

  // Reset: asynchronous assert, synchronous release.
  logic [SYNC_W-1:0] rst_pipe;
  logic              rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_W-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_W-1];

  path_mode_e mode;
  ecc_mode_pick u_mode (
    .loop_i    (loop_mode_i),
    .chk_i     (chk_mode_i),
    .raw_i     (raw_mode_i),
    .persist_i (raw_persist_i),
    .mode_o    (mode)
  );

  ecc_check_gen u_wr_gen (
    .data_i  (wr_data_i),
    .check_o (wr_check_o)
  );

  logic [DATA_W-1:0] dec_fixed, dec_raw;
  logic [CHK_W-1:0]  dec_chk;
  logic              dec_single, dec_multi;
  ecc_syndrome_fix u_dec (
    .word_i       (rd_word_i),
    .fixed_o      (dec_fixed),
    .raw_o        (dec_raw),
    .stored_chk_o (dec_chk),
    .single_o     (dec_single),
    .multi_o      (dec_multi)
  );

  // Loopback capture register and its generator.
  logic [DATA_W-1:0] lb_q, lb_d;
  logic              lb_en;
  logic [CHK_W-1:0]  lb_chk;

  ecc_check_gen u_lb_gen (
    .data_i  (lb_q),
    .check_o (lb_chk)
  );

  // Registered read result.
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_en;
  logic              corr_q, corr_d, unc_q, unc_d;

  always_comb begin
    lb_en = (mode == MODE_LOOP) && !oe_n_i;
    lb_d  = wr_data_i;

    rd_en  = rd_valid_i && (mode != MODE_LOOP);
    rd_d   = rd_q;
    corr_d = 1'b0;
    unc_d  = 1'b0;
    if (rd_en) begin
      unique case (mode)
        MODE_NORMAL: begin
          rd_d   = dec_fixed;
          corr_d = dec_single;
          unc_d  = dec_multi;
        end
        MODE_RAW:   rd_d = dec_raw;
        MODE_CHECK: rd_d = {{(DATA_W-CHK_W){1'b0}}, dec_chk};
        default:    rd_d = rd_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   lb_q <= '0;
    else if (lb_en) lb_q <= lb_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      corr_q <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end

  // Loopback output stays combinational from the capture register.
  assign dout_o          = (mode == MODE_LOOP) ? {{(DATA_W-CHK_W){1'b0}}, lb_chk} : rd_q;
  assign corrected_o     = corr_q;
  assign uncorrectable_o = unc_q;

endmodule

// File: rtl/byte_ecc_path_chk.sv
module byte_ecc_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] wr_check_o,
  input logic       rd_valid_i,
  input logic       oe_n_i,
  input logic       loop_mode_i,
  input logic       chk_mode_i,
  input logic [7:0] dout_o,
  input logic       corrected_o,
  input logic       uncorrectable_o
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(corrected_o && uncorrectable_o));

  assert_flags_need_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> (!corrected_o && !uncorrectable_o));

  assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid_i && !loop_mode_i) |=> (loop_mode_i || $stable(dout_o)));

  assert_chk_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && chk_mode_i && !loop_mode_i) |=> (loop_mode_i || dout_o[7:4] == 4'h0));

  assert_loop_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode_i && !oe_n_i) |=> (!loop_mode_i || dout_o == {4'h0, $past(wr_check_o)}));

  assert_loop_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && (loop_mode_i || chk_mode_i)) |=> !corrected_o);
endmodule

bind byte_ecc_path byte_ecc_path_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_check_o      (wr_check_o),
  .rd_valid_i      (rd_valid_i),
  .oe_n_i          (oe_n_i),
  .loop_mode_i     (loop_mode_i),
  .chk_mode_i      (chk_mode_i),
  .dout_o          (dout_o),
  .corrected_o     (corrected_o),
  .uncorrectable_o (uncorrectable_o)
);

// File: tb/byte_ecc_path_tb_top.sv
`timescale 1ns/1ps
module byte_ecc_path_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wr_data;
  logic [3:0]  wr_check;
  logic [11:0] rd_word;
  logic        rd_valid, oe_n, loop_m, chk_m, raw_m, persist;
  logic [7:0]  dout;
  logic        corr, unc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  byte_ecc_path dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_data_i       (wr_data),
    .wr_check_o      (wr_check),
    .rd_word_i       (rd_word),
    .rd_valid_i      (rd_valid),
    .oe_n_i          (oe_n),
    .loop_mode_i     (loop_m),
    .chk_mode_i      (chk_m),
    .raw_mode_i      (raw_m),
    .raw_persist_i   (persist),
    .dout_o          (dout),
    .corrected_o     (corr),
    .uncorrectable_o (unc)
  );

  // ---- reference arithmetic ----
  function automatic bit pos_is_chk(int p);
    return (p == 1) || (p == 2) || (p == 4) || (p == 8);
  endfunction

  function automatic logic [11:0] tb_place(logic [7:0] d);
    logic [11:0] w = '0;
    int j = 0;
    for (int p = 1; p <= 12; p++)
      if (!pos_is_chk(p)) begin w[p-1] = d[j]; j++; end
    return w;
  endfunction

  function automatic logic [7:0] tb_data(logic [11:0] w);
    logic [7:0] d = '0;
    int j = 0;
    for (int p = 1; p <= 12; p++)
      if (!pos_is_chk(p)) begin d[j] = w[p-1]; j++; end
    return d;
  endfunction

  function automatic logic [3:0] tb_syn(logic [11:0] w);
    int s = 0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ p;
    return 4'(s);
  endfunction

  function automatic logic [11:0] tb_encode(logic [7:0] d);
    logic [11:0] w = tb_place(d);
    logic [3:0]  s = tb_syn(w);
    w[0] = s[0]; w[1] = s[1]; w[3] = s[2]; w[7] = s[3];
    return w;
  endfunction

  function automatic logic [3:0] tb_checks(logic [11:0] w);
    return {w[7], w[3], w[1], w[0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [11:0] w, logic lp, logic ck, logic rw, logic ps);
    rd_word = w; loop_m = lp; chk_m = ck; raw_m = rw; persist = ps;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w, f;
    logic [7:0]  prev;
    rst_n = 1'b0; wr_data = '0; rd_word = '0; rd_valid = 1'b0; oe_n = 1'b1;
    loop_m = 1'b0; chk_m = 1'b0; raw_m = 1'b0; persist = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 dout", {8'h0, dout}, 16'h0);
    check("R10 flags", {14'h0, corr, unc}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    loop_m = 1'b1;  // R10 captured loopback byte starts at zero
    #1;
    check("R10 loop byte", {8'h0, dout}, {12'h0, tb_checks(tb_encode(8'h00))});
    loop_m = 1'b0;

    // R2 / R3 / R5 normal reads
    for (int v = 0; v < 256; v++) begin
      w = tb_encode(8'(v));
      do_read(w, 0, 0, 0, 0);
      check("R2 data", {8'h0, dout}, {8'h0, 8'(v)});
      check("R2 flags", {14'h0, corr, unc}, 16'h0);
      for (int p = 1; p <= 12; p++) begin
        do_read(w ^ (12'h1 << (p - 1)), 0, 0, 0, 0);
        check("R3 data", {8'h0, dout}, {8'h0, 8'(v)});
        check("R3 corrected", {14'h0, corr, unc}, 16'h2);
      end
      rd_word = ~w;
      @(negedge clk);
      check("R5 hold", {8'h0, dout}, {8'h0, 8'(v)});
      check("R5 pulse ends", {14'h0, corr, unc}, 16'h0);
    end

    // R4 uncorrectable double flips
    for (int v = 0; v < 256; v += 37) begin
      w = tb_encode(8'(v));
      for (int a = 1; a <= 12; a++)
        for (int b = a + 1; b <= 12; b++)
          if ((a ^ b) >= 13) begin
            f = w ^ (12'h1 << (a - 1)) ^ (12'h1 << (b - 1));
            do_read(f, 0, 0, 0, 0);
            check("R4 data", {8'h0, dout}, {8'h0, tb_data(f)});
            check("R4 flags", {14'h0, corr, unc}, 16'h1);
          end
    end

    // R6 raw mode, test select and persistent option
    for (int v = 0; v < 256; v += 3) begin
      w = tb_encode(8'(v));
      for (int p = 0; p <= 12; p++) begin
        f = (p == 0) ? w : (w ^ (12'h1 << (p - 1)));
        do_read(f, 0, 0, (p % 2) == 0, (p % 2) == 1);
        check("R6 raw data", {8'h0, dout}, {8'h0, tb_data(f)});
        check("R6 flags", {14'h0, corr, unc}, 16'h0);
      end
    end

    // R7 check-bit readout (R9: raw also high, check-bit wins)
    for (int v = 0; v < 256; v += 5) begin
      w = tb_encode(8'(v));
      for (int p = 0; p <= 12; p++) begin
        f = (p == 0) ? w : (w ^ (12'h1 << (p - 1)));
        do_read(f, 0, 1, (v % 2) == 1, 1'b0);
        check("R7 check bits", {8'h0, dout}, {12'h0, tb_checks(f)});
        check("R7 flags", {14'h0, corr, unc}, 16'h0);
      end
    end
    raw_m = 1'b0; chk_m = 1'b0;

    // R1 generator and R8 loopback
    do_read(tb_encode(8'h5A), 0, 0, 0, 0);
    prev = dout;
    for (int v = 0; v < 256; v++) begin
      wr_data = 8'(v); loop_m = 1'b1; oe_n = 1'b0;
      chk_m = (v % 3) == 0; raw_m = (v % 2) == 0;  // R9 loopback wins
      #1;
      check("R1 generator", {12'h0, wr_check}, {12'h0, tb_checks(tb_encode(8'(v)))});
      @(negedge clk);
      check("R8 loop echo", {8'h0, dout}, {12'h0, tb_checks(tb_encode(8'(v)))});
      oe_n = 1'b1; wr_data = ~8'(v);
      rd_word = tb_encode(8'hC3); rd_valid = 1'b1;  // R9 read ignored in loopback
      @(negedge clk);
      rd_valid = 1'b0;
      check("R8 hold while oe high", {8'h0, dout}, {12'h0, tb_checks(tb_encode(8'(v)))});
      check("R9 no flags", {14'h0, corr, unc}, 16'h0);
    end
    loop_m = 1'b0; chk_m = 1'b0; raw_m = 1'b0;
    #1;
    check("R9 read result kept", {8'h0, dout}, {8'h0, prev});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule